// File: doc/BRIEF.md
# LCD Common Scan and Frame Timing Generator

This block produces the row-scan timing of a multiplexed dot-matrix LCD driver. Two mode bits choose a duty: the number of rows shown and the height of the character font. With that duty the block steps a one-hot common select across the active commons. Each common lasts a fixed number of oscillator clocks, and that number depends on the duty. For each common the block gives the segment-data fetch a row index and issues a one-cycle latch strobe as the row begins. It also marks the second character line and the underline (cursor) row of a cell, and it drives the bias-ratio select.

A static strap picks one of two polarity-inversion schemes. With the per-row scheme the drive polarity flips in the middle of every common. With the per-frame scheme it flips once, as a new frame begins. Whenever the duty changes, the row counter and the clock divider restart from the first common. The analog levels, the font lookup and the segment shifting belong to neighbouring blocks.

Top module: `lcd_scan_timer`

## Requirements
- R1: Duty selection: two_line=1 scans 16 commons whatever tall_font is, two_line=0 with tall_font=0 scans 8 commons, and two_line=0 with tall_font=1 scans 11 commons.
- R2: Each common lasts CPC_LONG (default 800) clocks at the 8- and 11-common duties and CPC_SHORT (default 400) clocks at the 16-common duty, so a frame lasts commons times clocks per common.
- R3: com_sel is one-hot, with bit k high while row_idx equals k. Rows run 0,1,... up to the last active common and then wrap to 0.
- R4: row_strobe is high for exactly one cycle at the start of each common, in the cycle where that common's row_idx first appears.
- R5: bias_fifth is 1 when the duty is 16 commons (1/5 bias) and 0 at the 8- and 11-common duties (1/4 bias).
- R6: With wave_b=0, polarity toggles exactly once per common, CLOCKS/2 cycles after that common's strobe, and never in a strobe cycle.
- R7: With wave_b=1, polarity toggles once per frame, in the strobe cycle of row 0. It does not toggle on the first frame after a restart.
- R8: During reset and after any change of duty, the scan restarts at row 0 (com_sel=1) with the clock phase at 0. The first strobe of the restarted scan comes one cycle after the mode inputs change. polarity resets to 0 and is held through a restart.
- R9: line2 is 1 only at the 16-common duty while row_idx is 8 to 15 (second character line).
- R10: cursor_row is 1 while the row inside the character cell is the 8th, that is row_idx modulo 8 equals 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| two_line | input | 1 | 1 selects two character lines |
| tall_font | input | 1 | 1 selects the 5x10 font (one-line only) |
| wave_b | input | 1 | Strap: 0 per-row inversion, 1 per-frame inversion |
| com_sel | output | 16 | One-hot active common |
| row_idx | output | 4 | Index of the active common |
| row_strobe | output | 1 | One-cycle latch strobe at each common start |
| bias_fifth | output | 1 | 1 selects 1/5 bias, 0 selects 1/4 |
| polarity | output | 1 | Drive polarity |
| line2 | output | 1 | Active common belongs to character line 2 |
| cursor_row | output | 1 | Active common is the cell's underline row |

## Verification
Every cycle, the in-line assertions check that com_sel is one-hot and in range and that the strobe never lasts two cycles. They also check that a per-row polarity flip never lands on a strobe, that a per-frame flip lands only on the row 0 strobe, and that the second-line flag and the rows above eleven occur only with the 1/5 bias. A restart must also change the registered duty. Only the bench scenarios show the exact clock count of each common, the row order across whole frames at every duty, the midpoint position of the per-row flip, and the restart to row 0 after a mode change. The same scenarios show that the font bit has no effect in two-line mode and give the values of the cursor-row flag.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

   typedef enum logic [1:0] {
      DUTY_SHORT = 2'd0,
      DUTY_TALL  = 2'd1,
      DUTY_MULTI = 2'd2
   } duty_e;

   function automatic int commons_of(duty_e d, int cell_rows, int tall_rows, int lines);
      case (d)
         DUTY_TALL:  return tall_rows;
         DUTY_MULTI: return cell_rows * lines;
         default:    return cell_rows;
      endcase
   endfunction

   function automatic int clocks_of(duty_e d, int long_cpc, int short_cpc);
      return (d == DUTY_MULTI) ? short_cpc : long_cpc;
   endfunction

endpackage

// File: rtl/lcd_duty_select.sv
module lcd_duty_select
   import lcd_scan_pkg::*;
#(
   parameter int LINES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  two_line,
   input  logic  tall_font,
   output duty_e duty_q,
   output logic  restart
);

   duty_e duty_now;

   generate
      if (LINES > 1) begin : g_multi
         always_comb begin
            if (two_line)       duty_now = DUTY_MULTI;
            else if (tall_font) duty_now = DUTY_TALL;
            else                duty_now = DUTY_SHORT;
         end
      end else begin : g_single
         always_comb duty_now = tall_font ? DUTY_TALL : DUTY_SHORT;
      end
   endgenerate

   assign restart = rst_n && (duty_now != duty_q);

   always_ff @(posedge clk) begin
      if (!rst_n) duty_q <= duty_now;
      else        duty_q <= duty_now;
   end

   // R8
   restart_changes_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (duty_q != $past(duty_q)));

endmodule

// File: rtl/lcd_com_divider.sv
module lcd_com_divider #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] cpc,
   output logic [CNT_W-1:0] phase,
   output logic             at_start,
   output logic             at_end,
   output logic             mid_edge
);

   assign at_start = (phase == '0);
   assign at_end   = (phase == cpc - CNT_W'(1));
   assign mid_edge = (phase == (cpc >> 1) - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)                phase <= '0;
      else if (restart || at_end) phase <= '0;
      else                       phase <= phase + CNT_W'(1);
   end

   // R2
   phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase < cpc);

endmodule

// File: rtl/lcd_row_sequencer.sv
module lcd_row_sequencer #(
   parameter int MAX_COMMONS = 16,
   parameter int ROW_W       = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   restart,
   input  logic                   advance,
   input  logic [ROW_W-1:0]       last_row,
   output logic [ROW_W-1:0]       row,
   output logic [MAX_COMMONS-1:0] com_sel,
   output logic                   frame_last
);

   assign frame_last = (row == last_row);

   always_ff @(posedge clk) begin
      if (!rst_n)       row <= '0;
      else if (restart) row <= '0;
      else if (advance) row <= frame_last ? '0 : row + ROW_W'(1);
   end

   generate
      for (genvar g = 0; g < MAX_COMMONS; g++) begin : g_com
         assign com_sel[g] = (row == ROW_W'(g));
      end
   endgenerate

   // R3
   com_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(com_sel) == 1);

   // R3
   row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row <= last_row);

endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
   import lcd_scan_pkg::*;
#(
   parameter  int CELL_ROWS   = 8,
   parameter  int TALL_ROWS   = 11,
   parameter  int LINES       = 2,
   parameter  int CPC_LONG    = 800,
   parameter  int CPC_SHORT   = 400,
   localparam int MAX_COMMONS = CELL_ROWS * LINES,
   localparam int ROW_W       = $clog2(MAX_COMMONS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   two_line,
   input  logic                   tall_font,
   input  logic                   wave_b,
   output logic [MAX_COMMONS-1:0] com_sel,
   output logic [ROW_W-1:0]       row_idx,
   output logic                   row_strobe,
   output logic                   bias_fifth,
   output logic                   polarity,
   output logic                   line2,
   output logic                   cursor_row
);

   localparam int CPC_MAX = (CPC_LONG > CPC_SHORT) ? CPC_LONG : CPC_SHORT;
   localparam int CNT_W   = $clog2(CPC_MAX + 1);

   initial begin
      cpc_size_chk: assert (CPC_SHORT >= 4 && CPC_LONG >= 4)
         else $error("clocks per common must be at least 4");
      rows_order_chk: assert (TALL_ROWS > CELL_ROWS && TALL_ROWS <= MAX_COMMONS)
         else $error("tall font rows must lie between cell rows and total commons");
   end

   duty_e            duty_q;
   logic             restart;
   logic [CNT_W-1:0] cpc;
   logic [ROW_W-1:0] last_row;
   logic [CNT_W-1:0] phase;
   logic             at_start, at_end, mid_edge, frame_last;

   lcd_duty_select #(.LINES(LINES)) u_duty (
      .clk       (clk),
      .rst_n     (rst_n),
      .two_line  (two_line),
      .tall_font (tall_font),
      .duty_q    (duty_q),
      .restart   (restart)
   );

   assign cpc      = CNT_W'(clocks_of(duty_q, CPC_LONG, CPC_SHORT));
   assign last_row = ROW_W'(commons_of(duty_q, CELL_ROWS, TALL_ROWS, LINES) - 1);

   lcd_com_divider #(.CNT_W(CNT_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .cpc      (cpc),
      .phase    (phase),
      .at_start (at_start),
      .at_end   (at_end),
      .mid_edge (mid_edge)
   );

   lcd_row_sequencer #(.MAX_COMMONS(MAX_COMMONS), .ROW_W(ROW_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .advance    (at_end),
      .last_row   (last_row),
      .row        (row_idx),
      .com_sel    (com_sel),
      .frame_last (frame_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                        polarity <= 1'b0;
      else if (restart)                  polarity <= polarity;
      else if (wave_b && at_end && frame_last) polarity <= ~polarity;
      else if (!wave_b && mid_edge)      polarity <= ~polarity;
   end

   assign row_strobe = at_start && !restart;
   assign bias_fifth = (duty_q == DUTY_MULTI);
   assign line2      = (duty_q == DUTY_MULTI) && (int'(row_idx) >= CELL_ROWS);
   assign cursor_row = ((int'(row_idx) % CELL_ROWS) == CELL_ROWS - 1);

   // R4
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_strobe |=> !row_strobe);

   // R5
   bias_high_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(row_idx) >= TALL_ROWS) |-> bias_fifth);

   // R6
   row_flip_off_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wave_b && $stable(wave_b) && !restart && !$stable(polarity)) |-> !row_strobe);

   // R7
   frame_flip_at_row0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_b && $stable(wave_b) && !restart && !$stable(polarity))
         |-> (row_strobe && row_idx == '0));

   // R9
   line2_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line2 |-> (bias_fifth && int'(row_idx) >= CELL_ROWS));

endmodule

// File: tb/lcd_scan_timer_tb.sv
module lcd_scan_timer_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        two_line = 1'b0;
   logic        tall_font = 1'b0;
   logic        wave_b = 1'b0;
   logic [15:0] com_sel;
   logic [3:0]  row_idx;
   logic        row_strobe, bias_fifth, polarity, line2, cursor_row;

   lcd_scan_timer u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .two_line   (two_line),
      .tall_font  (tall_font),
      .wave_b     (wave_b),
      .com_sel    (com_sel),
      .row_idx    (row_idx),
      .row_strobe (row_strobe),
      .bias_fifth (bias_fifth),
      .polarity   (polarity),
      .line2      (line2),
      .cursor_row (cursor_row)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int row;
      int ncom;
      int gap;
      int tog;
      int off;
      bit wb;
   } item_t;

   item_t exp_q[$];
   int    errors = 0;
   int    checks = 0;
   bit    finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int ncom_of(bit tl, bit tf);
      if (tl) return 16;
      return tf ? 11 : 8;
   endfunction

   function automatic int cpc_of(int n);
      return (n == 16) ? 400 : 800;
   endfunction

   task automatic push_frames(input int n, input int frames, input int start_row,
                              input bit wb, input bit fresh);
      bit first = 1;
      for (int f = 0; f < frames; f++) begin
         for (int r = (f == 0) ? start_row : 0; r < n; r++) begin
            item_t it;
            it.row  = r;
            it.ncom = n;
            it.wb   = wb;
            it.gap  = (first && fresh) ? -1 : cpc_of(n);
            if (!wb) begin
               it.tog = 1; it.off = cpc_of(n) / 2;
            end else if (r == 0 && !(first && fresh)) begin
               it.tog = 1; it.off = 0;
            end else begin
               it.tog = 0; it.off = -1;
            end
            exp_q.push_back(it);
            first = 0;
         end
      end
   endtask

   task automatic switch_cfg(input bit tl, input bit tf, input bit wb, input int frames);
      wait (exp_q.size() == 0);
      repeat (3) @(negedge clk);
      two_line  = tl;
      tall_font = tf;
      wave_b    = wb;
      push_frames(ncom_of(tl, tf), frames, 0, wb, 1);
   endtask

   // R1: font bit flip in two-line mode must not restart the scan
   task automatic flip_font_two_line(input bit wb);
      wait (exp_q.size() == 0);
      repeat (3) @(negedge clk);
      tall_font = ~tall_font;
      push_frames(16, 1, 0, wb, 0);
   endtask

   // monitor: pops one expected item per observed strobe
   item_t cur, nx;
   bit    have_cur = 0;
   int    since = 0;
   int    tog_seen = 0;
   int    off_seen = -1;
   logic  prev_pol = 1'b0;

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_pol = polarity;
         since    = 0;
      end else begin
         since++;
         if (row_strobe) begin
            if (exp_q.size() == 0) begin
               chk(0, "R4", "unexpected strobe at row", int'(row_idx), -1);
            end else begin
               nx = exp_q.pop_front();
               if (have_cur && nx.gap >= 0) begin
                  chk(tog_seen == cur.tog, cur.wb ? "R7" : "R6",
                      "polarity toggles in common", tog_seen, cur.tog);
                  if (cur.tog == 1)
                     chk(off_seen == cur.off, cur.wb ? "R7" : "R6",
                         "polarity toggle offset", off_seen, cur.off);
               end
               chk(int'(row_idx) == nx.row, (nx.gap < 0) ? "R8" : "R3",
                   "row index", int'(row_idx), nx.row);
               chk(com_sel == (16'd1 << nx.row), "R3", "one-hot common",
                   int'(com_sel), 1 << nx.row);
               if (nx.gap >= 0)
                  chk(since == nx.gap, "R2", "clocks per common", since, nx.gap);
               chk(bias_fifth == (nx.ncom == 16), "R5", "bias select",
                   int'(bias_fifth), int'(nx.ncom == 16));
               chk(line2 == (nx.ncom == 16 && nx.row >= 8), "R9", "line2 flag",
                   int'(line2), int'(nx.ncom == 16 && nx.row >= 8));
               chk(cursor_row == ((nx.row % 8) == 7), "R10", "cursor row flag",
                   int'(cursor_row), int'((nx.row % 8) == 7));
               cur      = nx;
               have_cur = 1;
               tog_seen = 0;
               off_seen = -1;
            end
            since = 0;
         end
         if (polarity !== prev_pol) begin
            tog_seen++;
            if (off_seen < 0) off_seen = since;
         end
         prev_pol = polarity;
      end
   end

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "WD", "watchdog expired", 0, 1);
      report();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R8 reset state, R4 phase-0 strobe, R5 bias at 8 commons
      chk(com_sel == 16'd1, "R8", "reset com_sel", int'(com_sel), 1);
      chk(row_idx == 4'd0, "R8", "reset row", int'(row_idx), 0);
      chk(polarity == 1'b0, "R8", "reset polarity", int'(polarity), 0);
      chk(row_strobe == 1'b1, "R4", "reset phase strobe", int'(row_strobe), 1);
      chk(bias_fifth == 1'b0, "R5", "reset bias", int'(bias_fifth), 0);
      // R1: 8 commons; scan leaves phase 0 at the release edge, row 1 strobes first
      push_frames(8, 2, 1, 0, 1);
      rst_n <= 1'b1;
      // R1: 16 commons per-row inversion
      switch_cfg(1, 0, 0, 2);
      flip_font_two_line(0);
      // R1: 11 commons, per-frame inversion
      switch_cfg(0, 1, 1, 2);
      switch_cfg(0, 0, 1, 2);
      // R1: two_line with tall font still 16 commons
      switch_cfg(1, 1, 1, 2);
      switch_cfg(0, 1, 0, 2);
      wait (exp_q.size() == 0);
      repeat (5) @(negedge clk);
      report();
   end

endmodule